// File: doc/BRIEF.md
# Mini UART Register Front End with Receive Queue

This block is the software-facing side of a simple serial port, laid out like a reduced 16550. A processor reaches it through a 32-bit register window of 64 bytes. Bytes that arrive from a separate receiver are handed in over a valid/ready byte stream and queue in an eight-entry circular buffer, where software reads them from the data register. A write to the data register sends its low byte out on a transmit byte stream in the same cycle. The block has no serializer, so the transmit side always counts as empty and idle.

Interrupt enables, an interrupt identification word and two status words let a driver poll or wait for data. A level interrupt output is raised when received data is waiting and its enable is set, and also at any time the transmit enable is set. Line control, modem control, modem status, scratch and baud registers have an address but no storage. They read as zero and ignore writes. Only aligned accesses with all four byte enables set are decoded. Read data is registered.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the queue is empty, the pointer and the enables are zero, `irq` is low, `rx_ready` is high and every queue entry holds zero.
- R2: Received bytes are read back from the data register (offset 0x00) in arrival order, and the circular pointer wraps past the last entry.
- R3: `rx_ready` is high only while fewer than 8 bytes are held. A byte offered while the queue is full is not stored.
- R4: A data-register read of an empty queue returns the entry at the read pointer and changes neither the pointer nor the count.
- R5: A write to the enable register (offset 0x04) keeps bit 0 (receive) and bit 1 (transmit). A read returns 0xC0 OR the stored bits.
- R6: `irq` equals (receive enable AND queue non-empty) OR transmit enable.
- R7: A read of the identify register (offset 0x08) returns 0xC0, plus 0x4 if the queue holds data and 0x2 if it does not, plus 0x1 when `irq` is low.
- R8: A write to offset 0x08 with bit 1 set empties the queue. With bit 1 clear, the write has no effect.
- R9: The line status register (offset 0x14) reads 0x60 with bit 0 set when data is held. The extra control register (offset 0x20) reads 0x3.
- R10: The extra status register (offset 0x24) reads 0x30E, with bit 0 set when data is held and the fill count in bits 19:16.
- R11: A decoded write to offset 0x00 drives `tx_valid` high during the strobe cycle, with `tx_data` equal to the low 8 bits of the write data. `tx_valid` is low at all other times.
- R12: Offsets 0x0C, 0x10, 0x18, 0x1C and 0x28, any offset from 0x2C upward, and any access with a byte enable clear or with address bits 1:0 nonzero all read as zero or are ignored, and all of them leave state unchanged.
- R13: A push and a data-register pop in the same cycle keep the count and preserve order. A push in the same cycle as a flush leaves exactly that byte in the queue.
- R14: `bus_rdata` is loaded on the clock edge that ends a decoded read strobe and holds its value until the next decoded read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset in the window |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first is an accepted incoming byte together with a data-register pop. The second is an accepted incoming byte together with a flush write to the identify register. The bench raises `rx_valid` in the same cycle as the bus strobe. In the pop case it checks that the oldest byte is returned, that the fill count in the extra status word is unchanged and that the later reads keep arrival order. In the flush case it checks that the count reads one and that the surviving entry is the byte pushed during the flush.

// File: rtl/mini_uart_regs.sv
module mini_uart_regs #(
  parameter int DEPTH = 8,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] OFF_DATA  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_IEN   = AW'(8'h04);
  localparam logic [AW-1:0] OFF_IDENT = AW'(8'h08);
  localparam logic [AW-1:0] OFF_LSTAT = AW'(8'h14);
  localparam logic [AW-1:0] OFF_XCTRL = AW'(8'h20);
  localparam logic [AW-1:0] OFF_XSTAT = AW'(8'h24);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic [1:0]    ien;
  logic [31:0]   rd_mux;

  wire acc   = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire wr    = acc && bus_write;
  wire rd    = acc && !bus_write;
  wire has   = (cnt != '0);
  wire push  = rx_valid && rx_ready;
  wire pop   = rd && (bus_addr == OFF_DATA) && has;
  wire flush = wr && (bus_addr == OFF_IDENT) && bus_wdata[1];
  wire [PW-1:0] wslot = flush ? rd_ptr : rd_ptr + cnt[PW-1:0];

  assign rx_ready = (cnt < CW'(DEPTH));
  assign irq      = (ien[0] && has) || ien[1];
  assign tx_valid = wr && (bus_addr == OFF_DATA);
  assign tx_data  = bus_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      ien    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) mem[wslot] <= rx_data;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (flush) cnt <= CW'(push);
      else       cnt <= cnt + CW'(push) - CW'(pop);
      if (wr && bus_addr == OFF_IEN) ien <= bus_wdata[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_DATA:  rd_mux = {24'd0, mem[rd_ptr]};
      OFF_IEN:   rd_mux = {24'd0, 6'b110000, ien};
      OFF_IDENT: rd_mux = 32'hC0 | (has ? 32'h4 : 32'h2) | {31'd0, !irq};
      OFF_LSTAT: rd_mux = 32'h60 | {31'd0, has};
      OFF_XCTRL: rd_mux = 32'h3;
      OFF_XSTAT: rd_mux = 32'h30E | {31'd0, has} | (32'(cnt) << 16);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mini_uart_regs_chk.sv
module mini_uart_regs_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 6,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic [31:0]   bus_wdata,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          irq,
  input logic [PW-1:0] rd_ptr,
  input logic [CW-1:0] cnt,
  input logic [1:0]    ien
);
  wire full_acc = bus_sel && bus_be == 4'hF && bus_addr[1:0] == 2'b00;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !rx_ready); // R3
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_acc && !bus_write && bus_addr == '0 && cnt == '0 && !rx_valid)
    |=> (cnt == '0 && $stable(rd_ptr))); // R4
  AST_TX_EN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ien[1] |-> irq); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_acc && bus_write && bus_addr == AW'(8'h08) && bus_wdata[1] && !rx_valid)
    |=> cnt == '0); // R8
  AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (bus_sel && bus_write && tx_data == bus_wdata[7:0])); // R11
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_be != 4'hF && !rx_valid) |=> ($stable(cnt) && $stable(ien))); // R12
endmodule

bind mini_uart_regs mini_uart_regs_chk #(
  .DEPTH(DEPTH), .AW(AW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .irq(irq), .rd_ptr(rd_ptr), .cnt(cnt), .ien(ien)
);

// File: tb/mini_uart_regs_tb.sv
module mini_uart_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bsel = 0, bwr = 0;
  logic [5:0] baddr = 0;
  logic [3:0] bbe = 0;
  logic [31:0] bwdata = 0, rdata;
  logic rxv = 0, rxr, txv, irq;
  logic [7:0] rxd = 0, txd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mini_uart_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_write(bwr), .bus_addr(baddr),
    .bus_be(bbe), .bus_wdata(bwdata), .bus_rdata(rdata), .rx_valid(rxv),
    .rx_data(rxd), .rx_ready(rxr), .tx_valid(txv), .tx_data(txd), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk); bsel = 1; bwr = 0; baddr = a; bbe = be;
    @(negedge clk); bsel = 0; d = rdata;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, 4'hF, d);
    chk(d === exp, tag, d, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] v,
                    output logic tv, output logic [7:0] td);
    @(negedge clk); bsel = 1; bwr = 1; baddr = a; bbe = be; bwdata = v;
    #1 tv = txv; td = txd;
    @(negedge clk); bsel = 0; bwr = 0;
  endtask

  task automatic wr_q(input logic [5:0] a, input logic [31:0] v);
    logic tv; logic [7:0] td;
    wr(a, 4'hF, v, tv, td);
  endtask

  task automatic push(input logic [7:0] b, output logic rdy);
    @(negedge clk); rxv = 1; rxd = b;
    #1 rdy = rxr;
    @(negedge clk); rxv = 0;
  endtask

  task automatic t_reset;
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
    chk(rxr === 1'b1, "R1 rx_ready", {31'd0, rxr}, 1);
    rd_chk(6'h04, 32'hC0, "R1/R5 ien reset");
    rd_chk(6'h08, 32'hC3, "R1/R7 ident empty idle");
    rd_chk(6'h14, 32'h60, "R1/R9 lstat");
    rd_chk(6'h20, 32'h3, "R9 xctrl");
    rd_chk(6'h24, 32'h30E, "R1/R10 xstat");
    rd_chk(6'h00, 32'h0, "R1 entry zero");
  endtask

  task automatic t_order;
    logic r;
    for (int i = 0; i < 3; i++) push(8'hA1 + 8'(i), r);
    rd_chk(6'h24, 32'h0003030F, "R10 xstat 3");
    rd_chk(6'h14, 32'h61, "R9 lstat data");
    rd_chk(6'h08, 32'hC5, "R7 ident data no irq");
    for (int i = 0; i < 3; i++) rd_chk(6'h00, 32'hA1 + i, "R2 order");
  endtask

  task automatic t_full_wrap;
    logic r;
    for (int i = 0; i < 8; i++) begin
      push(8'h10 + 8'(i), r);
      chk(r === 1'b1, "R3 ready before full", {31'd0, r}, 1);
    end
    chk(rxr === 1'b0, "R3 ready low full", {31'd0, rxr}, 0);
    push(8'hEE, r);
    rd_chk(6'h24, 32'h0008030F, "R3/R10 xstat full");
    for (int i = 0; i < 8; i++) rd_chk(6'h00, 32'h10 + i, "R2/R3 wrap order");
    rd_chk(6'h00, 32'h10, "R4 stale entry");
    rd_chk(6'h14, 32'h60, "R4 still empty");
    push(8'h5A, r);
    rd_chk(6'h00, 32'h5A, "R4 pointer unchanged");
  endtask

  task automatic t_irq;
    logic r;
    wr_q(6'h04, 32'hFF);
    rd_chk(6'h04, 32'hC3, "R5 ien mask");
    chk(irq === 1'b1, "R6 tx en irq", {31'd0, irq}, 1);
    rd_chk(6'h08, 32'hC2, "R7 ident tx");
    wr_q(6'h04, 32'h1);
    chk(irq === 1'b0, "R6 rx en empty", {31'd0, irq}, 0);
    push(8'h77, r);
    chk(irq === 1'b1, "R6 rx en data", {31'd0, irq}, 1);
    rd_chk(6'h08, 32'hC4, "R7 ident rx");
    wr_q(6'h08, 32'h4);
    rd_chk(6'h14, 32'h61, "R8 no flush bit1 clear");
    wr_q(6'h08, 32'h2);
    rd_chk(6'h14, 32'h60, "R8 flush");
    chk(irq === 1'b0, "R6/R8 irq after flush", {31'd0, irq}, 0);
    wr_q(6'h04, 32'h0);
  endtask

  task automatic t_tx;
    logic tv; logic [7:0] td;
    wr(6'h00, 4'hF, 32'h1A5, tv, td);
    chk(tv === 1'b1, "R11 tx strobe", {31'd0, tv}, 1);
    chk(td === 8'hA5, "R11 tx byte", {24'd0, td}, 32'hA5);
    #1 chk(txv === 1'b0, "R11 tx idle", {31'd0, txv}, 0);
    wr(6'h00, 4'h1, 32'h33, tv, td);
    chk(tv === 1'b0, "R12 partial no tx", {31'd0, tv}, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr_q(6'h1C, 32'hFFFF_FFFF);
    rd_chk(6'h1C, 32'h0, "R12 scratch");
    rd_chk(6'h0C, 32'h0, "R12 lctrl");
    rd_chk(6'h28, 32'h0, "R12 baud");
    rd_chk(6'h30, 32'h0, "R12 beyond");
    wr(6'h04, 4'h3, 32'h3, d[0], d[15:8]);
    wr(6'h06, 4'hF, 32'h3, d[0], d[15:8]);
    rd_chk(6'h04, 32'hC0, "R12 partial/misaligned ignored");
    chk(irq === 1'b0, "R12 irq unchanged", {31'd0, irq}, 0);
  endtask

  task automatic t_hold;
    rd_chk(6'h20, 32'h3, "R14 load");
    @(negedge clk); @(negedge clk);
    chk(rdata === 32'h3, "R14 hold", rdata, 32'h3);
  endtask

  task automatic t_concurrent;
    logic r;
    push(8'hC1, r); push(8'hC2, r);
    @(negedge clk); bsel = 1; bwr = 0; baddr = 6'h00; bbe = 4'hF; rxv = 1; rxd = 8'hC3;
    @(negedge clk); bsel = 0; rxv = 0;
    chk(rdata === 32'hC1, "R13 pop during push", rdata, 32'hC1);
    rd_chk(6'h24, 32'h0002030F, "R13 count kept");
    rd_chk(6'h00, 32'hC2, "R13 order 1");
    rd_chk(6'h00, 32'hC3, "R13 order 2");
    push(8'hD1, r);
    @(negedge clk); bsel = 1; bwr = 1; baddr = 6'h08; bbe = 4'hF; bwdata = 32'h2; rxv = 1; rxd = 8'hD2;
    @(negedge clk); bsel = 0; bwr = 0; rxv = 0;
    rd_chk(6'h24, 32'h0001030F, "R13 flush keeps push");
    rd_chk(6'h00, 32'hD2, "R13 survivor");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full_wrap();
    t_irq();
    t_tx();
    t_unmapped();
    t_hold();
    t_concurrent();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule